// File: doc/BRIEF.md
# ADC Power Mode Sequencer

This controller sits between a host and an external pipelined converter. It drives the converter's active-low power-down and sleep pins. The host asks for a mode (active, sleep or power-down), and the controller walks the converter there in a safe order. It reports `ready` only once the converter's output samples can be trusted, and `busy` while a timed phase is running.

After reset the converter is always held in power-down for a minimum time. This gives the converter its mandatory reset pass before it may ever run. A request for power-down always wins over a request for sleep. Waking from power-down takes longer than waking from sleep because the references must settle again, so each idle mode has its own wake-up count. Both wake paths then wait a further pipeline-latency count before `ready` is raised. Leaving an idle mode for active operation also requires that the converter clock is reported as running.

The state machine has seven states:
- `ST_INIT`: mandatory power-down after reset.
- `ST_PDOWN`: power-down.
- `ST_SLEEP`: sleep.
- `ST_WAKE_PD`: wake-up count after power-down.
- `ST_WAKE_SL`: wake-up count after sleep.
- `ST_FLUSH`: pipeline-latency count.
- `ST_ACTIVE`: converter running, samples valid.

Its transitions are:
- `ST_INIT` goes to `ST_PDOWN`, `ST_SLEEP` or `ST_WAKE_PD` when the initial hold ends.
- `ST_PDOWN` goes to `ST_SLEEP` or `ST_WAKE_PD`.
- `ST_SLEEP` goes to `ST_PDOWN` or `ST_WAKE_SL`.
- Either wake state goes to `ST_FLUSH` when its count ends.
- `ST_FLUSH` goes to `ST_ACTIVE` when its count ends.
- Any of the two wake states, `ST_FLUSH` or `ST_ACTIVE` goes to `ST_PDOWN` or `ST_SLEEP` as soon as such a request appears (abort).

Top module: `adc_pwr_seq`

## Requirements
- R1: During reset and for `INIT_HOLD` (at least 4) clock cycles after reset release, `pdn_pin_n` is 0, `busy` is 1 and `ready` is 0, whatever the request.
- R2: `mode_req` encodes 2'b00 = active, 2'b01 = sleep, 2'b10 and 2'b11 = power-down; bit 1 set means power-down regardless of bit 0.
- R3: `pdn_pin_n` is 0 only in the initial hold and in power-down; `slp_pin_n` is 0 only in sleep; the two pins are never low together.
- R4: An active request while `clk_ok` is 0 leaves an idle mode unchanged (pins unchanged, `busy` stays 0) until `clk_ok` is 1.
- R5: An active request in power-down (or at the end of the initial hold) gives both pins high with `busy` = 1 for `PD_WAKE` + `PIPE_LAT` cycles, after which `ready` = 1 and `busy` = 0.
- R6: An active request in sleep gives both pins high with `busy` = 1 for `SLP_WAKE` + `PIPE_LAT` cycles, after which `ready` = 1.
- R7: A sleep or power-down request during a wake or latency count takes effect on the next clock edge; a later active request starts the full count again from the new idle mode.
- R8: `ready` is 1 only when both pins are high, and `ready` and `busy` are never 1 together.
- R9: From active, a power-down request drives `pdn_pin_n` low and `ready` low at the next edge; a sleep request does the same with `slp_pin_n`.
- R10: Power-down and sleep switch directly into each other at the next edge, with no wait and `busy` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req | input | 2 | Host mode request (see R2) |
| clk_ok | input | 1 | Converter clock is running |
| pdn_pin_n | output | 1 | Power-down pin, active low |
| slp_pin_n | output | 1 | Sleep pin, active low |
| ready | output | 1 | Converter samples are valid |
| busy | output | 1 | A timed phase is in progress |

## Verification
A wrong state register or a miscounted timer shows at the ports on the very cycle it happens. The pins, `ready` and `busy` are all decoded directly from the state, so a stray transition alters one of them at once. A wake count that is off by one shows as `ready` rising one cycle early or late after an active request. A missed abort shows as pins that stay high one cycle after a sleep or power-down request. The bench compares all four outputs against a behavioural model on every cycle, so each such fault is reported in the cycle where it first appears.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

    // Host request encoding; bit 1 dominates (power-down priority)
    typedef enum logic [1:0] {
        REQ_ACTIVE  = 2'b00,
        REQ_SLEEP   = 2'b01,
        REQ_PDOWN   = 2'b10,
        REQ_PDOWN_X = 2'b11
    } mode_req_e;

    typedef enum logic [2:0] {
        ST_INIT    = 3'd0,
        ST_PDOWN   = 3'd1,
        ST_SLEEP   = 3'd2,
        ST_WAKE_PD = 3'd3,
        ST_WAKE_SL = 3'd4,
        ST_FLUSH   = 3'd5,
        ST_ACTIVE  = 3'd6
    } seq_state_e;

endpackage

// File: rtl/adc_pwr_req_dec.sv
module adc_pwr_req_dec
    import adc_pwr_pkg::*;
(
    input  logic [1:0] mode_req,
    input  logic       clk_ok,
    output logic       want_pd,
    output logic       want_slp,
    output logic       want_act
);

    always_comb begin
        want_pd  = 1'b0;
        want_slp = 1'b0;
        want_act = 1'b0;
        unique case (mode_req)
            REQ_ACTIVE:            want_act = clk_ok;
            REQ_SLEEP:             want_slp = 1'b1;
            REQ_PDOWN, REQ_PDOWN_X: want_pd = 1'b1;
            default:               want_pd  = 1'b1;
        endcase
    end

endmodule

// File: rtl/adc_pwr_timer.sv
module adc_pwr_timer #(
    parameter int unsigned COUNT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int unsigned CW = $clog2(COUNT) + 1;
    localparam logic [CW-1:0] LAST = CW'(COUNT - 1);

    logic [CW-1:0] cnt_q;

    assign done = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (run && !done)
            cnt_q <= cnt_q + 1'b1;
        else
            cnt_q <= '0;
    end

endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
    import adc_pwr_pkg::*;
#(
    parameter int unsigned INIT_HOLD = 4,
    parameter int unsigned PD_WAKE   = 1024,
    parameter int unsigned SLP_WAKE  = 16,
    parameter int unsigned PIPE_LAT  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_req,
    input  logic       clk_ok,
    output logic       pdn_pin_n,
    output logic       slp_pin_n,
    output logic       ready,
    output logic       busy
);

    seq_state_e state_q, state_d;
    logic want_pd, want_slp, want_act;
    logic init_done, wpd_done, wsl_done, lat_done;

    adc_pwr_req_dec u_dec (
        .mode_req (mode_req),
        .clk_ok   (clk_ok),
        .want_pd  (want_pd),
        .want_slp (want_slp),
        .want_act (want_act)
    );

    adc_pwr_timer #(.COUNT(INIT_HOLD)) u_tmr_init (
        .clk(clk), .rst_n(rst_n), .run(state_q == ST_INIT), .done(init_done)
    );
    adc_pwr_timer #(.COUNT(PD_WAKE)) u_tmr_wpd (
        .clk(clk), .rst_n(rst_n), .run(state_q == ST_WAKE_PD), .done(wpd_done)
    );
    adc_pwr_timer #(.COUNT(SLP_WAKE)) u_tmr_wsl (
        .clk(clk), .rst_n(rst_n), .run(state_q == ST_WAKE_SL), .done(wsl_done)
    );
    adc_pwr_timer #(.COUNT(PIPE_LAT)) u_tmr_lat (
        .clk(clk), .rst_n(rst_n), .run(state_q == ST_FLUSH), .done(lat_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_INIT;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT: if (init_done) begin
                if (want_slp)      state_d = ST_SLEEP;
                else if (want_act) state_d = ST_WAKE_PD;
                else               state_d = ST_PDOWN;
            end
            ST_PDOWN: begin
                if (want_slp)      state_d = ST_SLEEP;
                else if (want_act) state_d = ST_WAKE_PD;
            end
            ST_SLEEP: begin
                if (want_pd)       state_d = ST_PDOWN;
                else if (want_act) state_d = ST_WAKE_SL;
            end
            ST_WAKE_PD: begin
                if (want_pd)       state_d = ST_PDOWN;
                else if (want_slp) state_d = ST_SLEEP;
                else if (wpd_done) state_d = ST_FLUSH;
            end
            ST_WAKE_SL: begin
                if (want_pd)       state_d = ST_PDOWN;
                else if (want_slp) state_d = ST_SLEEP;
                else if (wsl_done) state_d = ST_FLUSH;
            end
            ST_FLUSH: begin
                if (want_pd)       state_d = ST_PDOWN;
                else if (want_slp) state_d = ST_SLEEP;
                else if (lat_done) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (want_pd)       state_d = ST_PDOWN;
                else if (want_slp) state_d = ST_SLEEP;
            end
            default:               state_d = ST_INIT;
        endcase
    end

    always_comb begin
        pdn_pin_n = 1'b1;
        slp_pin_n = 1'b1;
        ready     = 1'b0;
        busy      = 1'b0;
        unique case (state_q)
            ST_INIT:    begin pdn_pin_n = 1'b0; busy = 1'b1; end
            ST_PDOWN:   pdn_pin_n = 1'b0;
            ST_SLEEP:   slp_pin_n = 1'b0;
            ST_WAKE_PD, ST_WAKE_SL, ST_FLUSH: busy = 1'b1;
            ST_ACTIVE:  ready = 1'b1;
            default:    begin pdn_pin_n = 1'b0; busy = 1'b1; end
        endcase
    end

    // R3
    pins_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!pdn_pin_n && !slp_pin_n));

    // R8
    ready_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (pdn_pin_n && slp_pin_n));

    // R8
    ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && busy));

    // R9
    pd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && want_pd) |=> (!pdn_pin_n && !ready));

    // R7
    wake_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pdn_pin_n && want_slp) |=> (!slp_pin_n && !busy));

    // R4
    clk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pdn_pin_n && !busy && mode_req == REQ_ACTIVE && !clk_ok) |=> (!busy && !pdn_pin_n));

    // R5
    rise_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(busy));

endmodule

// File: tb/adc_pwr_seq_test.sv
module adc_pwr_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int P_INIT = 4;
    localparam int P_PDW  = 20;
    localparam int P_SLW  = 5;
    localparam int P_LAT  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_req = 2'b00;
    logic       clk_ok = 1'b1;
    logic       pdn_pin_n, slp_pin_n, ready, busy;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;
    string cur_req = "R1";

    // model: phase 0 init, 1 power-down, 2 sleep, 3 waking, 4 running
    int ph = 0;
    int left = P_INIT;

    adc_pwr_seq #(
        .INIT_HOLD(P_INIT), .PD_WAKE(P_PDW), .SLP_WAKE(P_SLW), .PIPE_LAT(P_LAT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .clk_ok(clk_ok),
        .pdn_pin_n(pdn_pin_n), .slp_pin_n(slp_pin_n), .ready(ready), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph = 0;
            left = P_INIT;
        end else begin
            bit pdreq, slreq, actreq;
            pdreq  = mode_req[1];
            slreq  = (mode_req == 2'b01);
            actreq = (mode_req == 2'b00) && clk_ok;
            case (ph)
                0: begin
                    left = left - 1;
                    if (left == 0) begin
                        if (slreq) ph = 2;
                        else if (actreq) begin ph = 3; left = P_PDW + P_LAT; end
                        else ph = 1;
                    end
                end
                1: if (slreq) ph = 2;
                   else if (actreq) begin ph = 3; left = P_PDW + P_LAT; end
                2: if (pdreq) ph = 1;
                   else if (actreq) begin ph = 3; left = P_SLW + P_LAT; end
                3: if (pdreq) ph = 1;
                   else if (slreq) ph = 2;
                   else begin left = left - 1; if (left == 0) ph = 4; end
                default: if (pdreq) ph = 1; else if (slreq) ph = 2;
            endcase
        end
    end

    task automatic cmp(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            cmp("pdn_pin_n", pdn_pin_n, !(ph == 0 || ph == 1));
            cmp("slp_pin_n", slp_pin_n, !(ph == 2));
            cmp("ready", ready, ph == 4);
            cmp("busy", busy, ph == 0 || ph == 3);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1: reset hold while active is already requested
        cur_req = "R1";
        mode_req = 2'b00;
        clk_ok = 1'b1;
        run(3);
        #1 rst_n = 1'b1;
        run(P_INIT);
        // R5: wake from the initial power-down
        cur_req = "R5";
        run(P_PDW + P_LAT + 4);
        // R9: active -> power-down
        cur_req = "R9";
        mode_req = 2'b10;
        run(4);
        // R10: power-down -> sleep -> power-down
        cur_req = "R10";
        mode_req = 2'b01;
        run(3);
        mode_req = 2'b10;
        run(3);
        mode_req = 2'b01;
        run(2);
        // R6: wake from sleep
        cur_req = "R6";
        mode_req = 2'b00;
        run(P_SLW + P_LAT + 3);
        // R9: active -> sleep
        cur_req = "R9";
        mode_req = 2'b01;
        run(3);
        // R2: 2'b11 means power-down, dominating bit 0
        cur_req = "R2";
        mode_req = 2'b11;
        run(3);
        // R4: active request with clock stopped
        cur_req = "R4";
        clk_ok = 1'b0;
        mode_req = 2'b00;
        run(8);
        clk_ok = 1'b1;
        cur_req = "R5";
        run(P_PDW + P_LAT + 2);
        // R4 from sleep
        cur_req = "R4";
        mode_req = 2'b01;
        run(2);
        clk_ok = 1'b0;
        mode_req = 2'b00;
        run(5);
        clk_ok = 1'b1;
        // R7: abort during wake, then restart
        cur_req = "R7";
        run(3);
        mode_req = 2'b10;
        run(3);
        mode_req = 2'b00;
        run(7);
        mode_req = 2'b01;
        run(2);
        mode_req = 2'b00;
        run(P_SLW + 1);
        mode_req = 2'b10;
        run(2);
        mode_req = 2'b00;
        run(P_PDW + P_LAT + 3);
        // R8: steady active, then reset in mid-operation
        cur_req = "R8";
        run(5);
        cur_req = "R1";
        mode_req = 2'b01;
        #1 rst_n = 1'b0;
        run(2);
        #1 rst_n = 1'b1;
        run(P_INIT + 4);
        cur_req = "R3";
        mode_req = 2'b00;
        run(P_SLW + P_LAT + 3);
        finished = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule